// File: doc/BRIEF.md
# SMBus battery register target

This block is a target on a two-wire SMBus segment. It gives a host controller access to a bank of 16-bit registers. The clock and data lines are brought in as plain inputs. The block drives the data line only through a pull-low enable, which models the open-drain connection. Both lines are sampled by the system clock through synchronisers. START and STOP are recognised from the relation between the two lines, and bits are taken on clock rising edges. The data line is moved only after clock falling edges.

A message opens with the fixed address 0x0B in the upper seven bits of the first byte and the direction flag in bit 0, so the address byte is 0x16 for a write and 0x17 for a read. The next byte is a command code. Its low bits select the register, and its top bit selects a block read in place of a word read. A word write carries a low byte and then a high byte, and takes effect at the STOP that closes the message. A read sends a repeated START and then the read address. The target then returns either a word (low byte first) or a block: first a byte count, then consecutive registers, each low byte first, with the register index wrapping around the bank.

Every message may end with a packet error code. This is a CRC-8 (polynomial x^8+x^2+x+1, start value 0) taken over every byte of the message, including both address bytes. On a write the target checks the code and refuses a bad one. On a read the target appends the code when the host acknowledges the last data byte.

Top module: `smb_batt_target`

## Requirements
- R1: After reset the pull-low enable is off and every register reads 0x0000.
- R2: An address byte equal to 0x16 or 0x17 is acknowledged. Any other address byte is not acknowledged, and the target leaves the data line released for the rest of that message, so a write inside it changes nothing.
- R3: A write message of 0x16, command, low byte, high byte and STOP acknowledges every byte and stores {high, low} in the register given by command bits [3:0].
- R4: A write that carries a fifth byte equal to the CRC-8 of the four preceding bytes acknowledges that byte and stores the word at STOP.
- R5: A write whose fifth byte differs from that CRC-8 has that byte not acknowledged, and the register keeps its old value.
- R6: A word read (0x16, command with bit 7 clear, repeated START, 0x17) returns the register low byte and then the high byte, each sent most significant bit first.
- R7: If the host acknowledges the high byte of a word read, the next byte is the CRC-8 over 0x16, command, 0x17, low byte and high byte.
- R8: A read whose command has bit 7 set returns a count of 2*BLK_WORDS (4 by default), then registers base, base+1 and so on, with base = command[3:0] and the index taken modulo 16, each register low byte first.
- R9: If the host acknowledges the last block byte, the target appends the CRC-8 over every byte of the message, including the count.
- R10: After the host does not acknowledge a read byte, the target releases the data line, and further clocks read 0xFF.
- R11: A write that a repeated START interrupts before any STOP is discarded.
- R12: The data line driven by the target changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull the data line low when 1 |

## Verification
The hardest case to reach is a packet error code carried inside a read. The code depends on bytes that both sides send, and it is only sent when the host chooses to acknowledge the last data byte. Cases that are equally hard to reach are a block read whose base index wraps past the end of the bank, and a write that a repeated START cuts short. The bench builds each of these from directed bus sequences. It then mixes seeded random writes, word reads and block reads, with and without codes and with deliberately corrupted codes, and checks every returned byte and code against a register model and a CRC computed in the bench.

// File: rtl/smb_batt_pkg.sv
`timescale 1ns/1ps
package smb_batt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } smb_state_e;

  // CRC-8, polynomial 0x07, one byte per call
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int i = 0; i < 8; i++) begin
      x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    end
    return x;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_s      = scl_q[STAGES-1];
  assign sda_s      = sda_q[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
`timescale 1ns/1ps
module smb_reg_bank #(
  parameter int REG_NUM = 16,
  parameter int DW      = 16,
  localparam int IDXW   = $clog2(REG_NUM)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [IDXW-1:0] widx_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [IDXW-1:0] ridx_i,
  output logic [DW-1:0]   rdata_o
);

  logic [DW-1:0] mem [REG_NUM];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < REG_NUM; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[widx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[ridx_i];

endmodule

// File: rtl/smb_batt_target.sv
`timescale 1ns/1ps
module smb_batt_target
  import smb_batt_pkg::*;
#(
  parameter logic [6:0] ADDR      = 7'h0B,
  parameter int         REG_NUM   = 16,
  parameter int         BLK_WORDS = 2,
  parameter int         SYNC_STG  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);

  localparam int IDXW      = $clog2(REG_NUM);
  localparam int BLK_BYTES = 2 * BLK_WORDS;
  localparam int TXIW      = $clog2(BLK_BYTES + 3);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  smb_line_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  smb_state_e      state;
  logic [3:0]      bit_cnt;
  logic [7:0]      sr, tx_sr, crc, wr_lo, wr_hi, tx_byte;
  logic [IDXW-1:0] cmd_idx, rd_idx;
  logic            cmd_blk, blk, addr_ph, go_tx, wr_seg, pec_ok, mack, in_msg, oe, reg_we;
  logic [2:0]      wr_cnt;
  logic [TXIW-1:0] tx_idx, bsel, toff, tx_last;
  logic [15:0]     rdata;

  smb_reg_bank #(.REG_NUM(REG_NUM), .DW(16)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we),
    .widx_i  (cmd_idx),
    .wdata_i ({wr_hi, wr_lo}),
    .ridx_i  (rd_idx),
    .rdata_o (rdata)
  );

  // byte to send for the current read position
  always_comb begin
    bsel    = tx_idx - 1'b1;
    toff    = bsel >> 1;
    tx_last = blk ? TXIW'(BLK_BYTES + 1) : TXIW'(2);
    rd_idx  = cmd_idx;
    if (blk && tx_idx != '0) rd_idx = cmd_idx + IDXW'(toff);
    tx_byte = crc;
    if (!blk) begin
      if (tx_idx == TXIW'(0))      tx_byte = rdata[7:0];
      else if (tx_idx == TXIW'(1)) tx_byte = rdata[15:8];
    end else if (tx_idx == TXIW'(0)) begin
      tx_byte = 8'(BLK_BYTES);
    end else if (tx_idx <= TXIW'(BLK_BYTES)) begin
      tx_byte = bsel[0] ? rdata[15:8] : rdata[7:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      sr      <= '0;
      tx_sr   <= '0;
      crc     <= '0;
      wr_lo   <= '0;
      wr_hi   <= '0;
      cmd_idx <= '0;
      cmd_blk <= 1'b0;
      blk     <= 1'b0;
      addr_ph <= 1'b0;
      go_tx   <= 1'b0;
      wr_seg  <= 1'b0;
      pec_ok  <= 1'b0;
      mack    <= 1'b0;
      in_msg  <= 1'b0;
      oe      <= 1'b0;
      reg_we  <= 1'b0;
      wr_cnt  <= '0;
      tx_idx  <= '0;
    end else begin
      reg_we <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        oe     <= 1'b0;
        in_msg <= 1'b0;
        wr_seg <= 1'b0;
        if (wr_seg && (wr_cnt == 3'd3 || (wr_cnt == 3'd4 && pec_ok))) reg_we <= 1'b1;
      end else if (start_det) begin
        state   <= ST_RX;
        bit_cnt <= '0;
        addr_ph <= 1'b1;
        oe      <= 1'b0;
        wr_seg  <= 1'b0;
        in_msg  <= 1'b1;
        if (!in_msg) crc <= '0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              sr      <= {sr[6:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              crc   <= crc8_step(crc, sr);
              state <= ST_IDLE;
              if (addr_ph) begin
                addr_ph <= 1'b0;
                if (sr[7:1] == ADDR) begin
                  oe     <= 1'b1;
                  state  <= ST_RX_ACK;
                  go_tx  <= sr[0];
                  wr_seg <= ~sr[0];
                  wr_cnt <= '0;
                  tx_idx <= '0;
                  blk    <= cmd_blk;
                end
              end else begin
                wr_cnt <= (wr_cnt == 3'd5) ? wr_cnt : wr_cnt + 1'b1;
                case (wr_cnt)
                  3'd0: begin cmd_idx <= sr[IDXW-1:0]; cmd_blk <= sr[7]; oe <= 1'b1; state <= ST_RX_ACK; end
                  3'd1: begin wr_lo <= sr; oe <= 1'b1; state <= ST_RX_ACK; end
                  3'd2: begin wr_hi <= sr; oe <= 1'b1; state <= ST_RX_ACK; end
                  3'd3: begin
                    pec_ok <= (sr == crc);
                    if (sr == crc) begin oe <= 1'b1; state <= ST_RX_ACK; end
                  end
                  default: ;
                endcase
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_rise) begin
              bit_cnt <= 4'd9;
            end else if (scl_fall && bit_cnt == 4'd9) begin
              bit_cnt <= '0;
              if (go_tx) begin
                state <= ST_TX;
                tx_sr <= tx_byte;
                oe    <= ~tx_byte[7];
              end else begin
                oe    <= 1'b0;
                state <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              oe    <= 1'b0;
              state <= ST_TX_ACK;
              crc   <= crc8_step(crc, tx_byte);
            end else if (scl_fall) begin
              tx_sr <= tx_sr << 1;
              oe    <= ~tx_sr[6];
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack    <= ~sda_s;
              bit_cnt <= 4'd9;
              tx_idx  <= tx_idx + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd9) begin
              bit_cnt <= '0;
              if (mack && tx_idx <= tx_last) begin
                state <= ST_TX;
                tx_sr <= tx_byte;
                oe    <= ~tx_byte[7];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe;

endmodule

// File: rtl/smb_batt_target_chk.sv
`timescale 1ns/1ps
module smb_batt_target_chk
  import smb_batt_pkg::*;
#(
  parameter int TXIW   = 3,
  parameter int TX_MAX = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sda_oe_o,
  input logic            scl_fall,
  input logic            start_det,
  input logic            stop_det,
  input logic            reg_we,
  input smb_state_e      state,
  input logic [TXIW-1:0] tx_idx
);

  // R12: drive changes only after a clock fall (or a bus condition)
  a_r12_oe_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_fall && !start_det && !stop_det) |=> $stable(sda_oe_o));

  // R3: register update only right after a STOP
  a_r3_write_at_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we |-> $past(stop_det));

  // R2: no drive while waiting for the next START
  a_r2_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !sda_oe_o);

  // R8: read position never runs past the final code byte
  a_r8_tx_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_idx <= TXIW'(TX_MAX));

  // R10: the target is not driving while the host answers a read byte
  a_r10_host_ack_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_TX_ACK) |-> !sda_oe_o);

endmodule

bind smb_batt_target smb_batt_target_chk #(.TXIW(TXIW), .TX_MAX(BLK_BYTES + 2)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sda_oe_o  (sda_oe_o),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .reg_we    (reg_we),
  .state     (state),
  .tx_idx    (tx_idx)
);

// File: tb/smb_batt_target_bench.sv
`timescale 1ns/1ps
module smb_batt_target_bench;

  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  smb_batt_target u_smb_batt_target (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] mdl [16];

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_q;
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wait_q;
    scl_m = 1'b1; wait_q;
    sda_m = 1'b0; wait_q;
    scl_m = 1'b0; wait_q;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wait_q;
    scl_m = 1'b1; wait_q;
    sda_m = 1'b1; wait_q;
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q;
      scl_m = 1'b1; wait_q; wait_q;
      scl_m = 1'b0; wait_q;
    end
    sda_m = 1'b1; wait_q;
    scl_m = 1'b1; wait_q;
    ack = ~sda_line; wait_q;
    scl_m = 1'b0; wait_q;
  endtask

  task automatic get_byte(input bit ack, output logic [7:0] b);
    bit steady;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wait_q;
      scl_m = 1'b1; wait_q;
      b[i] = sda_line; wait_q;
      if (sda_line !== b[i]) steady = 1'b0;
      scl_m = 1'b0; wait_q;
    end
    check(steady, "R12 data stable while clock high", 32'(steady), 1);
    sda_m = ~ack; wait_q;
    scl_m = 1'b1; wait_q; wait_q;
    scl_m = 1'b0; wait_q;
  endtask

  task automatic wr_word(input logic [7:0] cmd, input logic [15:0] d, input bit pec, input bit bad);
    bit a0, a1, a2, a3, ap;
    logic [7:0] c;
    c = crc8(crc8(crc8(crc8(8'h00, 8'h16), cmd), d[7:0]), d[15:8]);
    bus_start;
    put_byte(8'h16, a0);
    put_byte(cmd, a1);
    put_byte(d[7:0], a2);
    put_byte(d[15:8], a3);
    check(a0 & a1 & a2 & a3, "R3 write bytes acked", {a0, a1, a2, a3}, 4'hF);
    if (pec) begin
      put_byte(bad ? (c ^ 8'h5A) : c, ap);
      if (bad) check(!ap, "R5 bad code refused", ap, 0);
      else     check(ap, "R4 good code acked", ap, 1);
    end
    bus_stop;
    if (!(pec && bad)) mdl[cmd[3:0]] = d;
  endtask

  task automatic rd_word(input logic [7:0] cmd, input bit pec, input string req);
    bit a0, a1, a2;
    logic [7:0] lo, hi, p, c;
    logic [15:0] exp;
    exp = mdl[cmd[3:0]];
    bus_start;
    put_byte(8'h16, a0);
    put_byte(cmd, a1);
    bus_start;
    put_byte(8'h17, a2);
    check(a0 & a1 & a2, "R2 read addressing acked", {a0, a1, a2}, 3'h7);
    get_byte(1'b1, lo);
    get_byte(pec, hi);
    check({hi, lo} == exp, req, {hi, lo}, exp);
    if (pec) begin
      c = crc8(crc8(crc8(crc8(crc8(8'h00, 8'h16), cmd), 8'h17), lo), hi);
      get_byte(1'b0, p);
      check(p == c, "R7 word read code", p, c);
    end
    bus_stop;
  endtask

  task automatic rd_block(input logic [7:0] cmd, input bit pec);
    bit a0, a1, a2;
    logic [7:0] b, c, e;
    logic [3:0] wi;
    c = crc8(crc8(crc8(8'h00, 8'h16), cmd), 8'h17);
    bus_start;
    put_byte(8'h16, a0);
    put_byte(cmd, a1);
    bus_start;
    put_byte(8'h17, a2);
    check(a0 & a1 & a2, "R2 block addressing acked", {a0, a1, a2}, 3'h7);
    get_byte(1'b1, b);
    check(b == 8'd4, "R8 block count", b, 4);
    c = crc8(c, b);
    for (int k = 0; k < 4; k++) begin
      wi = cmd[3:0] + 4'(k / 2);
      e = (k % 2 == 1) ? mdl[wi][15:8] : mdl[wi][7:0];
      get_byte((k < 3) || pec, b);
      check(b == e, "R8 block data", b, e);
      c = crc8(c, b);
    end
    if (pec) begin
      get_byte(1'b0, b);
      check(b == c, "R9 block code", b, c);
    end
    bus_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] b;
    int op;
    void'($urandom(32'h5EED_2060));
    for (int i = 0; i < 16; i++) mdl[i] = 16'h0000;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    wait_q;
    check(sda_oe == 1'b0, "R1 released after reset", sda_oe, 0);
    rd_word(8'h00, 1'b0, "R1 reset value reg0");
    rd_word(8'h0F, 1'b0, "R1 reset value reg15");

    wr_word(8'h03, 16'hA55A, 1'b0, 1'b0);
    rd_word(8'h03, 1'b0, "R6 word read after R3 write");
    wr_word(8'h09, 16'h8001, 1'b0, 1'b0);
    rd_word(8'h09, 1'b0, "R6 msb first");

    wr_word(8'h05, 16'h1234, 1'b1, 1'b0);
    rd_word(8'h05, 1'b1, "R4 stored with good code");
    wr_word(8'h05, 16'hBEEF, 1'b1, 1'b1);
    rd_word(8'h05, 1'b1, "R5 unchanged after bad code");

    // foreign address: nothing acked, nothing stored
    bus_start;
    put_byte(8'h20, a);
    check(!a, "R2 foreign address not acked", a, 0);
    put_byte(8'h03, a);
    check(!a, "R2 no drive after mismatch", a, 0);
    put_byte(8'h11, a);
    put_byte(8'h22, a);
    check(!a, "R2 no drive after mismatch", a, 0);
    bus_stop;
    rd_word(8'h03, 1'b0, "R2 reg untouched by foreign write");

    // write cut by repeated START
    bus_start;
    put_byte(8'h16, a);
    put_byte(8'h07, a);
    put_byte(8'h77, a);
    put_byte(8'h66, a);
    bus_start;
    bus_stop;
    rd_word(8'h07, 1'b0, "R11 interrupted write discarded");

    // release after host NACK
    bus_start;
    put_byte(8'h16, a);
    put_byte(8'h03, a);
    bus_start;
    put_byte(8'h17, a);
    get_byte(1'b1, b);
    get_byte(1'b0, b);
    get_byte(1'b0, b);
    check(b == 8'hFF, "R10 released after NACK", b, 8'hFF);
    bus_stop;

    wr_word(8'h0E, 16'hC3D4, 1'b0, 1'b0);
    wr_word(8'h0F, 16'hE5F6, 1'b1, 1'b0);
    wr_word(8'h00, 16'h0102, 1'b0, 1'b0);
    rd_block(8'h8E, 1'b0);
    rd_block(8'h8F, 1'b1);

    for (int t = 0; t < 36; t++) begin
      op = int'($urandom % 4);
      case (op)
        0, 1: wr_word({4'h0, 4'($urandom)}, 16'($urandom), 1'($urandom), ($urandom % 4) == 0);
        2: rd_word({4'h0, 4'($urandom)}, 1'($urandom), "R6 random word read");
        default: rd_block({4'h8, 4'($urandom)}, 1'($urandom));
      endcase
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule